// File: doc/BRIEF.md
# Paging Address Translator with Lookup Buffer

This block turns a logical address from a processor into a physical address by paging. The upper bits of the logical address select a page and the lower bits give the offset inside it. The block looks the page up in a small fully associative translation buffer. On a hit, the frame number comes back in the same cycle. On a miss, the block reads one page-table entry from an external memory, returns the translation and stores it in the buffer for later requests.

Two checks come before any memory access. A page number beyond the table length register faults at once. A fetched entry whose valid bit is clear faults instead of translating. Software loads the table base and table length registers, and pulses a flush input on every context switch to empty the buffer. Two counters report how many lookups hit and how many missed, so that an observer can work out the hit ratio.

The processor raises `reqValid` with `reqLaddr` and holds both until `respGrant` is high for one cycle. It issues one request at a time.

Top module: `paging_mmu`

## Requirements
- R1: A page of 2^OFFSET_W bytes splits the logical address into page number `reqLaddr[LADDR_W-1:OFFSET_W]` and offset `reqLaddr[OFFSET_W-1:0]`. A successful translation returns `{frame, offset}` with the offset unchanged.
- R2: When the requested page is held in the buffer, `respGrant` rises in the request cycle with the stored frame, no memory read is issued, and `hitCount` increments by one.
- R3: On a buffer miss, `memRdEn` pulses for one cycle in the request cycle with `memRdAddr = ptBase + page` (one entry per memory word, wrapping at PT_ADDR_W bits), and `missCount` increments by one. `respGrant` is asserted in the cycle `memRdValid` is high, whatever the memory latency.
- R4: A page-table entry is `{valid, frame}`, with the valid flag at bit FRAME_W and the frame in bits FRAME_W-1:0. After a miss returns a valid entry, the next request to that page hits.
- R5: A page number greater than or equal to the table length register is granted in the request cycle with `respFault` high, issues no memory read and changes neither counter.
- R6: A fetched entry with its valid bit clear is granted with `respFault` high and is not inserted, so a repeat request to that page misses again.
- R7: A `tlbFlush` pulse invalidates every buffer entry, so every later request misses until it is refilled.
- R8: A refill fills the lowest-numbered empty slot first. When every slot is full it evicts in round-robin order starting at slot 0, and a flush resets that order to slot 0.
- R9: Only one table read is outstanding at a time, and `memRdEn` is never high in the same cycle as `respGrant`.
- R10: A flush that arrives while a table read is outstanding still lets the response return to the processor, but no buffer entry is written from that read.
- R11: After reset, both counters are zero, the table length is zero so every request faults, and `respGrant` stays low while no request is present.
- R12: Whenever `respFault` is high together with `respGrant`, `respPaddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Translation request, held until granted |
| reqLaddr | input | LADDR_W | Logical address |
| respGrant | output | 1 | Translation complete this cycle |
| respFault | output | 1 | Bound or invalid-entry fault, qualified by respGrant |
| respPaddr | output | FRAME_W+OFFSET_W | Physical address, qualified by respGrant |
| memRdEn | output | 1 | Page-table read strobe |
| memRdAddr | output | PT_ADDR_W | Page-table word address |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | FRAME_W+1 | Page-table entry `{valid, frame}` |
| ptBaseLoad | input | 1 | Load the table base register |
| ptBaseIn | input | PT_ADDR_W | New table base |
| ptLenLoad | input | 1 | Load the table length register |
| ptLenIn | input | LADDR_W-OFFSET_W+1 | New table length in entries |
| tlbFlush | input | 1 | Invalidate all buffer entries |
| hitCount | output | CNT_W | Lookups that hit |
| missCount | output | CNT_W | Lookups that missed |

## Verification
The bench keeps the default parameters: 13-bit logical addresses, 1 KB pages and so eight pages, 8-bit frames, and four buffer slots. Eight pages against four slots makes eviction reachable within a few requests, so the round-robin victim order and the preference for empty slots can be checked one step at a time. The memory model's latency can be changed, which leaves room to land a flush in the middle of a table read.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_WALK
  } mmu_state_t;

  typedef struct packed {
    logic grant;
    logic fault;
    logic memRd;
    logic latchReq;
    logic refill;
    logic useWalk;
    logic countHit;
    logic countMiss;
  } mmu_strobe_t;

endpackage

// File: rtl/mmu_tlb.sv
module mmu_tlb #(
  parameter int ENTRIES = 4,
  parameter int PAGE_W  = 3,
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [PAGE_W-1:0]  lookupPage,
  output logic               hit,
  output logic [FRAME_W-1:0] hitFrame,
  input  logic               refill,
  input  logic [PAGE_W-1:0]  refillPage,
  input  logic [FRAME_W-1:0] refillFrame,
  output logic [ENTRIES-1:0] validVec
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [PAGE_W-1:0]  pageQ  [ENTRIES];
  logic [FRAME_W-1:0] frameQ [ENTRIES];
  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]   rrPtr;
  logic [IDX_W-1:0]   freeIdx;
  logic [IDX_W-1:0]   victim;
  logic               haveFree;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign matchVec[g] = validQ[g] && (pageQ[g] == lookupPage);
  end

  always_comb begin
    hitFrame = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) hitFrame = hitFrame | frameQ[i];
    end
  end

  assign hit = |matchVec;

  // Lowest-numbered empty slot wins; otherwise the round-robin pointer.
  always_comb begin
    haveFree = 1'b0;
    freeIdx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validQ[i]) begin
        haveFree = 1'b1;
        freeIdx  = IDX_W'(i);
      end
    end
  end

  assign victim = haveFree ? freeIdx : rrPtr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validQ <= '0;
      rrPtr  <= '0;
    end else if (flush) begin
      validQ <= '0;
      rrPtr  <= '0;
    end else if (refill) begin
      validQ[victim] <= 1'b1;
      if (!haveFree) rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (refill && !flush) begin
      pageQ[victim]  <= refillPage;
      frameQ[victim] <= refillFrame;
    end
  end

  assign validVec = validQ;

endmodule

// File: rtl/mmu_datapath.sv
module mmu_datapath
  import mmu_pkg::*;
#(
  parameter int LADDR_W     = 13,
  parameter int OFFSET_W    = 10,
  parameter int FRAME_W     = 8,
  parameter int PT_ADDR_W   = 8,
  parameter int TLB_ENTRIES = 4,
  parameter int CNT_W       = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  mmu_strobe_t                   strobe,
  input  logic [LADDR_W-1:0]            reqLaddr,
  input  logic                          ptBaseLoad,
  input  logic [PT_ADDR_W-1:0]          ptBaseIn,
  input  logic                          ptLenLoad,
  input  logic [LADDR_W-OFFSET_W:0]     ptLenIn,
  input  logic                          tlbFlush,
  input  logic [FRAME_W:0]              memRdData,
  output logic                          hit,
  output logic                          boundFault,
  output logic                          pteValid,
  output logic [FRAME_W+OFFSET_W-1:0]   respPaddr,
  output logic [PT_ADDR_W-1:0]          memRdAddr,
  output logic [CNT_W-1:0]              hitCount,
  output logic [CNT_W-1:0]              missCount,
  output logic [LADDR_W-OFFSET_W:0]     ptLenQ,
  output logic [TLB_ENTRIES-1:0]        tlbValidQ
);
  localparam int PAGE_W = LADDR_W - OFFSET_W;

  logic [PAGE_W-1:0]    reqPage;
  logic [OFFSET_W-1:0]  reqOff;
  logic [PAGE_W-1:0]    walkPage;
  logic [OFFSET_W-1:0]  walkOff;
  logic [PT_ADDR_W-1:0] ptBaseQ;
  logic [FRAME_W-1:0]   hitFrame;
  logic [FRAME_W-1:0]   pteFrame;

  assign reqPage  = reqLaddr[LADDR_W-1:OFFSET_W];
  assign reqOff   = reqLaddr[OFFSET_W-1:0];
  assign pteValid = memRdData[FRAME_W];
  assign pteFrame = memRdData[FRAME_W-1:0];

  assign boundFault = ({1'b0, reqPage} >= ptLenQ);
  assign memRdAddr  = ptBaseQ + PT_ADDR_W'(reqPage);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptBaseQ <= '0;
      ptLenQ  <= '0;
    end else begin
      if (ptBaseLoad) ptBaseQ <= ptBaseIn;
      if (ptLenLoad)  ptLenQ  <= ptLenIn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walkPage <= '0;
      walkOff  <= '0;
    end else if (strobe.latchReq) begin
      walkPage <= reqPage;
      walkOff  <= reqOff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hitCount  <= '0;
      missCount <= '0;
    end else begin
      if (strobe.countHit)  hitCount  <= hitCount + 1'b1;
      if (strobe.countMiss) missCount <= missCount + 1'b1;
    end
  end

  always_comb begin
    if (strobe.fault)        respPaddr = '0;
    else if (strobe.useWalk) respPaddr = {pteFrame, walkOff};
    else                     respPaddr = {hitFrame, reqOff};
  end

  mmu_tlb #(
    .ENTRIES (TLB_ENTRIES),
    .PAGE_W  (PAGE_W),
    .FRAME_W (FRAME_W)
  ) u_tlb (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (tlbFlush),
    .lookupPage  (reqPage),
    .hit         (hit),
    .hitFrame    (hitFrame),
    .refill      (strobe.refill),
    .refillPage  (walkPage),
    .refillFrame (pteFrame),
    .validVec    (tlbValidQ)
  );

endmodule

// File: rtl/mmu_ctrl.sv
module mmu_ctrl
  import mmu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        hit,
  input  logic        boundFault,
  input  logic        memRdValid,
  input  logic        pteValid,
  input  logic        tlbFlush,
  output mmu_strobe_t strobe
);
  mmu_state_t stateQ, stateD;
  logic       abortQ, abortD;

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    abortD = abortQ;
    case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          if (boundFault) begin
            strobe.grant = 1'b1;
            strobe.fault = 1'b1;
          end else if (hit) begin
            strobe.grant    = 1'b1;
            strobe.countHit = 1'b1;
          end else begin
            strobe.memRd     = 1'b1;
            strobe.latchReq  = 1'b1;
            strobe.countMiss = 1'b1;
            abortD           = 1'b0;
            stateD           = ST_WALK;
          end
        end
      end
      ST_WALK: begin
        strobe.useWalk = 1'b1;
        if (tlbFlush) abortD = 1'b1;
        if (memRdValid) begin
          strobe.grant  = 1'b1;
          strobe.fault  = !pteValid;
          strobe.refill = pteValid && !abortQ && !tlbFlush;
          stateD        = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      abortQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      abortQ <= abortD;
    end
  end

endmodule

// File: rtl/paging_mmu.sv
module paging_mmu
  import mmu_pkg::*;
#(
  parameter int LADDR_W     = 13,
  parameter int OFFSET_W    = 10,
  parameter int FRAME_W     = 8,
  parameter int PT_ADDR_W   = 8,
  parameter int TLB_ENTRIES = 4,
  parameter int CNT_W       = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reqValid,
  input  logic [LADDR_W-1:0]            reqLaddr,
  output logic                          respGrant,
  output logic                          respFault,
  output logic [FRAME_W+OFFSET_W-1:0]   respPaddr,
  output logic                          memRdEn,
  output logic [PT_ADDR_W-1:0]          memRdAddr,
  input  logic                          memRdValid,
  input  logic [FRAME_W:0]              memRdData,
  input  logic                          ptBaseLoad,
  input  logic [PT_ADDR_W-1:0]          ptBaseIn,
  input  logic                          ptLenLoad,
  input  logic [LADDR_W-OFFSET_W:0]     ptLenIn,
  input  logic                          tlbFlush,
  output logic [CNT_W-1:0]              hitCount,
  output logic [CNT_W-1:0]              missCount
);
  mmu_strobe_t                 strobe;
  logic                        hit;
  logic                        boundFault;
  logic                        pteValid;
  logic [LADDR_W-OFFSET_W:0]   ptLenQ;
  logic [TLB_ENTRIES-1:0]      tlbValidQ;

  mmu_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .hit        (hit),
    .boundFault (boundFault),
    .memRdValid (memRdValid),
    .pteValid   (pteValid),
    .tlbFlush   (tlbFlush),
    .strobe     (strobe)
  );

  mmu_datapath #(
    .LADDR_W     (LADDR_W),
    .OFFSET_W    (OFFSET_W),
    .FRAME_W     (FRAME_W),
    .PT_ADDR_W   (PT_ADDR_W),
    .TLB_ENTRIES (TLB_ENTRIES),
    .CNT_W       (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .reqLaddr   (reqLaddr),
    .ptBaseLoad (ptBaseLoad),
    .ptBaseIn   (ptBaseIn),
    .ptLenLoad  (ptLenLoad),
    .ptLenIn    (ptLenIn),
    .tlbFlush   (tlbFlush),
    .memRdData  (memRdData),
    .hit        (hit),
    .boundFault (boundFault),
    .pteValid   (pteValid),
    .respPaddr  (respPaddr),
    .memRdAddr  (memRdAddr),
    .hitCount   (hitCount),
    .missCount  (missCount),
    .ptLenQ     (ptLenQ),
    .tlbValidQ  (tlbValidQ)
  );

  assign respGrant = strobe.grant;
  assign respFault = strobe.fault;
  assign memRdEn   = strobe.memRd;

endmodule

// File: rtl/mmu_checker.sv
module mmu_checker #(
  parameter int LADDR_W     = 13,
  parameter int OFFSET_W    = 10,
  parameter int FRAME_W     = 8,
  parameter int TLB_ENTRIES = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        reqValid,
  input logic [LADDR_W-1:0]          reqLaddr,
  input logic                        respGrant,
  input logic                        respFault,
  input logic [FRAME_W+OFFSET_W-1:0] respPaddr,
  input logic                        memRdEn,
  input logic                        tlbFlush,
  input logic [LADDR_W-OFFSET_W:0]   ptLenQ,
  input logic [TLB_ENTRIES-1:0]      tlbValidQ
);
  logic [LADDR_W-OFFSET_W-1:0] curPage;
  assign curPage = reqLaddr[LADDR_W-1:OFFSET_W];

  assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (respGrant && !respFault) |-> (respPaddr[OFFSET_W-1:0] == reqLaddr[OFFSET_W-1:0]));

  assert_grant_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(respGrant && memRdEn));

  assert_read_in_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    memRdEn |-> ({1'b0, curPage} < ptLenQ));

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tlbFlush |=> (tlbValidQ == '0));

  assert_single_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    memRdEn |=> !memRdEn);

  assert_grant_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    respGrant |-> reqValid);

  assert_fault_zero_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (respGrant && respFault) |-> (respPaddr == '0));

endmodule

bind paging_mmu mmu_checker #(
  .LADDR_W     (LADDR_W),
  .OFFSET_W    (OFFSET_W),
  .FRAME_W     (FRAME_W),
  .TLB_ENTRIES (TLB_ENTRIES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reqValid  (reqValid),
  .reqLaddr  (reqLaddr),
  .respGrant (respGrant),
  .respFault (respFault),
  .respPaddr (respPaddr),
  .memRdEn   (memRdEn),
  .tlbFlush  (tlbFlush),
  .ptLenQ    (ptLenQ),
  .tlbValidQ (tlbValidQ)
);

// File: tb/sim_paging_mmu.sv
`timescale 1ns/1ps
module sim_paging_mmu;
  localparam int LADDR_W = 13;
  localparam int OFFSET_W = 10;
  localparam int FRAME_W = 8;
  localparam int PT_ADDR_W = 8;
  localparam int CNT_W = 16;
  localparam logic [PT_ADDR_W-1:0] BASE = 8'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic [LADDR_W-1:0] reqLaddr = '0;
  logic respGrant, respFault;
  logic [FRAME_W+OFFSET_W-1:0] respPaddr;
  logic memRdEn;
  logic [PT_ADDR_W-1:0] memRdAddr;
  logic memRdValid = 1'b0;
  logic [FRAME_W:0] memRdData = '0;
  logic ptBaseLoad = 1'b0;
  logic [PT_ADDR_W-1:0] ptBaseIn = '0;
  logic ptLenLoad = 1'b0;
  logic [LADDR_W-OFFSET_W:0] ptLenIn = '0;
  logic tlbFlush = 1'b0;
  logic [CNT_W-1:0] hitCount, missCount;

  int nChecks = 0;
  int nFails = 0;
  int memReads = 0;
  int latency = 0;
  int expHits = 0;
  int expMiss = 0;

  logic [FRAME_W:0] ptMem [256];
  logic pending = 1'b0;
  int waitCnt = 0;
  logic [PT_ADDR_W-1:0] pendAddr;

  always #2.5 clk = ~clk;

  paging_mmu u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqLaddr(reqLaddr),
    .respGrant(respGrant), .respFault(respFault), .respPaddr(respPaddr),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdValid(memRdValid),
    .memRdData(memRdData), .ptBaseLoad(ptBaseLoad), .ptBaseIn(ptBaseIn),
    .ptLenLoad(ptLenLoad), .ptLenIn(ptLenIn), .tlbFlush(tlbFlush),
    .hitCount(hitCount), .missCount(missCount)
  );

  // Page-table memory with adjustable latency.
  always @(posedge clk) begin
    if (memRdEn) begin
      memReads <= memReads + 1;
      pending  <= 1'b1;
      waitCnt  <= latency;
      pendAddr <= memRdAddr;
    end
  end

  always @(negedge clk) begin
    memRdValid = 1'b0;
    if (pending) begin
      if (waitCnt == 0) begin
        memRdValid = 1'b1;
        memRdData  = ptMem[pendAddr];
        pending    = 1'b0;
      end else begin
        waitCnt = waitCnt - 1;
      end
    end
  end

  function automatic logic [FRAME_W-1:0] frameOf(input int p);
    return FRAME_W'(8'h11 + p * 8'h1d);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic xlate(input logic [LADDR_W-1:0] la, output bit flt,
                       output logic [FRAME_W+OFFSET_W-1:0] pa,
                       output int cyc, output int rd);
    int snap;
    bit got;
    @(negedge clk);
    snap = memReads;
    reqValid = 1'b1;
    reqLaddr = la;
    cyc = 0;
    got = 1'b0;
    while (!got && cyc < 60) begin
      #1;
      if (respGrant) begin
        got = 1'b1;
        flt = respFault;
        pa = respPaddr;
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    if (!got) begin
      check(1'b0, "R9", "grant timeout", cyc, 0);
      flt = 1'b1;
      pa = '0;
    end
    rd = memReads - snap;
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  // Expect a hit (isHit) or a miss of a valid in-bound page.
  task automatic expectXlate(input int p, input int off, input bit isHit, input string req);
    bit f; logic [FRAME_W+OFFSET_W-1:0] pa; int c; int r;
    xlate({p[LADDR_W-OFFSET_W-1:0], off[OFFSET_W-1:0]}, f, pa, c, r);
    if (isHit) expHits++; else expMiss++;
    check(!f, req, $sformatf("fault page %0d", p), f, 0);
    check(pa == {frameOf(p), off[OFFSET_W-1:0]}, req, $sformatf("paddr page %0d", p),
          pa, {frameOf(p), off[OFFSET_W-1:0]});
    check(r == (isHit ? 0 : 1), req, $sformatf("reads page %0d", p), r, isHit ? 0 : 1);
    check(c == (isHit ? 0 : 1 + latency), req, $sformatf("cycles page %0d", p),
          c, isHit ? 0 : 1 + latency);
  endtask

  task automatic pulseFlush();
    @(negedge clk); tlbFlush = 1'b1;
    @(negedge clk); tlbFlush = 1'b0;
  endtask

  task automatic loadLen(input int n);
    @(negedge clk); ptLenLoad = 1'b1; ptLenIn = n[LADDR_W-OFFSET_W:0];
    @(negedge clk); ptLenLoad = 1'b0;
  endtask

  task automatic checkCounters(input string req);
    #1;
    check(hitCount == CNT_W'(expHits), req, "hitCount", hitCount, expHits);
    check(missCount == CNT_W'(expMiss), req, "missCount", missCount, expMiss);
  endtask

  task automatic t_reset();
    bit f; logic [FRAME_W+OFFSET_W-1:0] pa; int c; int r;
    @(negedge clk); #1;
    check(respGrant == 1'b0, "R11", "idle grant", respGrant, 0);
    checkCounters("R11");
    xlate(13'h0123, f, pa, c, r);
    check(f == 1'b1, "R11", "fault with zero length", f, 1);
    check(r == 0, "R5", "no read on bound fault", r, 0);
    check(pa == '0, "R12", "fault paddr", pa, 0);
    checkCounters("R5");
  endtask

  task automatic t_setup();
    @(negedge clk); ptBaseLoad = 1'b1; ptBaseIn = BASE;
    @(negedge clk); ptBaseLoad = 1'b0;
    loadLen(6);
  endtask

  task automatic t_missHit();
    expectXlate(1, 'h155, 1'b0, "R3");
    expectXlate(1, 'h2aa, 1'b1, "R2");
    expectXlate(1, 'h3ff, 1'b1, "R1");
    latency = 4;
    expectXlate(3, 'h001, 1'b0, "R3");
    expectXlate(3, 'h000, 1'b1, "R4");
    latency = 0;
    checkCounters("R2");
  endtask

  task automatic t_bound();
    bit f; logic [FRAME_W+OFFSET_W-1:0] pa; int c; int r;
    for (int p = 6; p < 8; p++) begin
      xlate({p[2:0], 10'h0aa}, f, pa, c, r);
      check(f && c == 0, "R5", $sformatf("bound fault page %0d", p), f, 1);
      check(r == 0, "R5", "bound no read", r, 0);
    end
    checkCounters("R5");
    expectXlate(5, 'h0aa, 1'b0, "R5");
    loadLen(8);
    expectXlate(7, 'h077, 1'b0, "R5");
    loadLen(6);
  endtask

  task automatic t_invalid();
    bit f; logic [FRAME_W+OFFSET_W-1:0] pa; int c; int r;
    for (int k = 0; k < 2; k++) begin
      xlate({3'd2, 10'h123}, f, pa, c, r);
      expMiss++;
      check(f == 1'b1, "R6", "invalid entry faults", f, 1);
      check(r == 1, "R6", "invalid entry not cached", r, 1);
      check(pa == '0, "R12", "invalid paddr", pa, 0);
    end
    checkCounters("R6");
  endtask

  task automatic t_flush();
    expectXlate(4, 'h010, 1'b0, "R7");
    expectXlate(4, 'h011, 1'b1, "R7");
    pulseFlush();
    expectXlate(4, 'h012, 1'b0, "R7");
    expectXlate(1, 'h012, 1'b0, "R7");
  endtask

  task automatic t_replace();
    pulseFlush();
    expectXlate(0, 1, 1'b0, "R8");  // slot0
    expectXlate(1, 2, 1'b0, "R8");  // slot1
    expectXlate(3, 3, 1'b0, "R8");  // slot2
    expectXlate(4, 4, 1'b0, "R8");  // slot3
    expectXlate(5, 5, 1'b0, "R8");  // evicts slot0 (page 0)
    expectXlate(1, 6, 1'b1, "R8");
    expectXlate(0, 7, 1'b0, "R8");  // evicts slot1 (page 1)
    expectXlate(3, 8, 1'b1, "R8");
    expectXlate(1, 9, 1'b0, "R8");  // evicts slot2 (page 3)
    expectXlate(4, 10, 1'b1, "R8");
    expectXlate(3, 11, 1'b0, "R8"); // evicts slot3 (page 4)
    expectXlate(5, 12, 1'b1, "R8");
    checkCounters("R8");
  endtask

  task automatic t_flushWalk();
    int snap;
    bit got;
    logic [FRAME_W+OFFSET_W-1:0] pa;
    pulseFlush();
    latency = 3;
    @(negedge clk);
    snap = memReads;
    reqValid = 1'b1;
    reqLaddr = {3'd4, 10'h2c3};
    expMiss++;
    @(negedge clk);
    tlbFlush = 1'b1;
    @(negedge clk);
    tlbFlush = 1'b0;
    got = 1'b0;
    pa = '0;
    for (int k = 0; k < 20 && !got; k++) begin
      #1;
      if (respGrant) begin got = 1'b1; pa = respPaddr; end
      else @(negedge clk);
    end
    check(got, "R10", "response after flush", got, 1);
    check(pa == {frameOf(4), 10'h2c3}, "R10", "paddr after flush", pa, {frameOf(4), 10'h2c3});
    check(memReads - snap == 1, "R9", "single read in flight", memReads - snap, 1);
    @(posedge clk);
    #1 reqValid = 1'b0;
    latency = 0;
    expectXlate(4, 'h2c4, 1'b0, "R10");
    checkCounters("R10");
  endtask

  initial begin
    for (int a = 0; a < 256; a++) ptMem[a] = '0;
    for (int p = 0; p < 8; p++) ptMem[BASE + p] = {(p != 2), frameOf(p)};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_setup();
    t_missHit();
    t_bound();
    t_invalid();
    t_flush();
    t_replace();
    t_flushWalk();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #200000;
    nChecks++;
    nFails++;
    $display("FAIL R9 watchdog expired: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule